// File: doc/BRIEF.md
# Modulo-Scheduled Loop Controller

This block sequences one tile of a software-pipelined loop on a fixed-function processor. The host loads an iteration count and pulses a start input. While the tile runs, a phase counter steps through the initiation interval (II) cycles of each iteration. Its value goes out on a port that steers the operand and opcode multiplexers in front of shared function units. At every wrap of the phase counter the controller pulses a shift strobe to the register FIFOs and, while iterations remain, counts one more iteration as issued.

After the last iteration has been issued, no new one enters the pipeline. The controller keeps stepping the phase for a fixed drain time of (STAGES-1)*II cycles, which is the schedule length minus II. It then raises a done flag that the host polls before it reads live-out values. A per-stage valid vector tells which pipeline stages hold a real iteration. It is the predicate that lets fill and drain run on the same hardware as steady state.

Top module: `mod_loop_ctrl`

## Requirements
- R1: After reset, busy_o=0, done_o=0, shift_o=0, phase_o=0 and stage_vld_o is all zero.
- R2: A start with trip count N>0, accepted in idle or done, makes busy_o high from the next cycle for N*II + (STAGES-1)*II cycles. During that time phase_o counts 0,1,...,II-1 cyclically, starting at 0 in the first busy cycle.
- R3: shift_o is high for exactly one cycle in every busy cycle whose phase is II-1, giving N+STAGES-1 pulses per tile. The phase is 0 in the cycle after each pulse.
- R4: In busy cycle c (counted from 0), with slot s = floor(c/II), bit k of stage_vld_o (bit 0 being the first stage) is 1 exactly when 0 <= s-k < N.
- R5: After the last busy cycle, done_o=1, busy_o=0 and stage_vld_o is zero.
- R6: A start with trip count 0 raises done_o in the next cycle, with no busy cycle and no shift pulse.
- R7: A start pulse while busy_o=1 is ignored. The tile in progress keeps its length, phase sequence and valid pattern.
- R8: done_o stays high until the next accepted start. That start clears it in the next cycle when N>0.
- R9: While not busy, shift_o stays 0 and phase_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse from the host |
| trip_cnt_i | input | TRIP_W | Iteration count sampled with an accepted start |
| phase_o | output | PH_W | Current phase within II, steers operand multiplexers |
| shift_o | output | 1 | One-cycle FIFO shift strobe at each phase wrap |
| stage_vld_o | output | STAGES | Per-stage predicate, bit 0 is the first stage |
| busy_o | output | 1 | High while issuing or draining |
| done_o | output | 1 | Tile finished, held until the next start |

## Verification
The assertions assume that trip_cnt_i is only meaningful in the cycle where a start is accepted. They also assume that a start arriving while busy has no effect on the remaining count or on the phase. The stimulus drives start and the trip count only on falling edges, as single-cycle pulses. It sweeps every trip count from 0 to 6 in one small configuration (II=3, three stages), and for one run it issues a start in the middle of the tile. Between runs the bench leaves the block in done for several cycles, so that the hold of done and its clearing by the next start are both exercised.

// File: rtl/lpc_pkg.sv
// Shared types for the loop controller.
package lpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } lpc_state_e;
endpackage

// File: rtl/lpc_phase_cnt.sv
// Phase counter: steps 0..II-1 while enabled and flags the last phase.
// Assumes clr_i and en_i are never both high.
module lpc_phase_cnt #(
    parameter int II   = 3,
    parameter int PH_W = (II > 1) ? $clog2(II) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            en_i,
    output logic [PH_W-1:0] phase_o,
    output logic            wrap_o
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(II - 1);

    // Marks the final phase of an interval while counting.
    assign wrap_o = en_i && (phase_o == LAST_PH);

    // Advances the phase and returns to 0 after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            phase_o <= '0;
        else if (en_i)
            phase_o <= wrap_o ? '0 : phase_o + 1'b1;
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o <= LAST_PH); // R2
endmodule

// File: rtl/lpc_trip_cnt.sv
// Remaining-iteration counter: loaded at start, decremented per issued iteration.
// Assumes dec_i is only raised while the count is nonzero.
module lpc_trip_cnt #(
    parameter int TRIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TRIP_W-1:0] load_val_i,
    input  logic              dec_i,
    output logic [TRIP_W-1:0] remain_o,
    output logic              last_o
);
    // Flags the final iteration of the tile.
    assign last_o = (remain_o == TRIP_W'(1));

    // Loads the trip count or counts one iteration down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_o <= '0;
        else if (load_i)
            remain_o <= load_val_i;
        else if (dec_i)
            remain_o <= remain_o - 1'b1;
    end

    AST_TRIP_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (remain_o != '0)); // R2
endmodule

// File: rtl/lpc_drain_cnt.sv
// Drain timer: counts DRAIN_CYC cycles while enabled and flags the last one.
// With DRAIN_CYC of zero the timer is absent and last_o is tied high.
module lpc_drain_cnt #(
    parameter int DRAIN_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic last_o
);
    generate
        if (DRAIN_CYC == 0) begin : g_none
            assign last_o = 1'b1;
        end else begin : g_cnt
            localparam int DC_W = (DRAIN_CYC > 1) ? $clog2(DRAIN_CYC) : 1;
            logic [DC_W-1:0] cnt_q;

            // Flags the final drain cycle.
            assign last_o = (cnt_q == DC_W'(DRAIN_CYC - 1));

            // Counts elapsed drain cycles.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)
                    cnt_q <= '0;
                else if (en_i && !last_o)
                    cnt_q <= cnt_q + 1'b1;
            end

            AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= DC_W'(DRAIN_CYC - 1)); // R5
        end
    endgenerate
endmodule

// File: rtl/lpc_stage_vld.sv
// Stage-valid shift register: bit k marks a real iteration in stage k.
// A seed sets only the first stage. Each shift moves the bits one stage deeper
// and feeds fill_i into the first stage.
module lpc_stage_vld #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_i,
    input  logic              shift_i,
    input  logic              fill_i,
    output logic [STAGES-1:0] vld_o
);
    logic [STAGES-1:0] shifted;

    // Forms the shifted vector, with a single-stage variant.
    generate
        if (STAGES == 1) begin : g_one
            assign shifted = fill_i;
        end else begin : g_many
            assign shifted = {vld_o[STAGES-2:0], fill_i};
        end
    endgenerate

    // Seeds the first stage at start and advances at every shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_o <= '0;
        else if (seed_i)
            vld_o <= STAGES'(1);
        else if (shift_i)
            vld_o <= shifted;
    end
endmodule

// File: rtl/mod_loop_ctrl.sv
// Loop controller for one tile of a modulo-scheduled loop.
// Holds the IDLE/RUN/DRAIN/DONE sequence and combines the phase counter,
// the trip counter, the drain timer and the stage-valid register.
// Assumes start_i is a pulse and trip_cnt_i is valid in the start cycle.
module mod_loop_ctrl
    import lpc_pkg::*;
#(
    parameter int II     = 3,
    parameter int STAGES = 3,
    parameter int TRIP_W = 8,
    parameter int PH_W   = (II > 1) ? $clog2(II) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TRIP_W-1:0] trip_cnt_i,
    output logic [PH_W-1:0]   phase_o,
    output logic              shift_o,
    output logic [STAGES-1:0] stage_vld_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int DRAIN_CYC = (STAGES - 1) * II;

    lpc_state_e        state_q, state_d;
    logic              accept, wrap, trip_last, drain_last;
    logic [TRIP_W-1:0] remain;

    // Accepts a start only from idle or done.
    assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign busy_o = (state_q == ST_RUN) || (state_q == ST_DRAIN);
    assign done_o = (state_q == ST_DONE);
    assign shift_o = wrap;

    // Chooses the next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE:
                if (accept) state_d = (trip_cnt_i == '0) ? ST_DONE : ST_RUN;
            ST_RUN:
                if (wrap && trip_last) state_d = (DRAIN_CYC == 0) ? ST_DONE : ST_DRAIN;
            ST_DRAIN:
                if (drain_last) state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    lpc_phase_cnt #(.II(II), .PH_W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr_i(!busy_o), .en_i(busy_o),
        .phase_o(phase_o), .wrap_o(wrap)
    );

    lpc_trip_cnt #(.TRIP_W(TRIP_W)) u_trip (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .load_val_i(trip_cnt_i),
        .dec_i(wrap && (state_q == ST_RUN)), .remain_o(remain), .last_o(trip_last)
    );

    lpc_drain_cnt #(.DRAIN_CYC(DRAIN_CYC)) u_drain (
        .clk(clk), .rst_n(rst_n), .clr_i(state_q != ST_DRAIN),
        .en_i(state_q == ST_DRAIN), .last_o(drain_last)
    );

    lpc_stage_vld #(.STAGES(STAGES)) u_vld (
        .clk(clk), .rst_n(rst_n), .seed_i(accept && (trip_cnt_i != '0)),
        .shift_i(wrap), .fill_i((state_q == ST_RUN) && !trip_last),
        .vld_o(stage_vld_o)
    );

    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (stage_vld_o == '0)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!shift_o && (phase_o == '0))); // R9
    AST_SHIFT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> (phase_o == '0)); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !shift_o) |=> $stable(remain)); // R7
    AST_ZERO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (trip_cnt_i == '0)) |=> (done_o && !busy_o)); // R6
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i && (trip_cnt_i != '0)) |=> (busy_o && !done_o)); // R8
endmodule

// File: tb/mod_loop_ctrl_tb.sv
// Sweeps trip counts 0..6 with II=3 and three stages and checks every cycle
// of each tile against arithmetic expectations.
module mod_loop_ctrl_tb;
    localparam int II     = 3;
    localparam int STAGES = 3;
    localparam int TRIP_W = 4;
    localparam int PH_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [TRIP_W-1:0] trip_cnt_i = '0;
    logic [PH_W-1:0]   phase_o;
    logic              shift_o;
    logic [STAGES-1:0] stage_vld_o;
    logic              busy_o;
    logic              done_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    mod_loop_ctrl #(.II(II), .STAGES(STAGES), .TRIP_W(TRIP_W), .PH_W(PH_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .trip_cnt_i(trip_cnt_i),
        .phase_o(phase_o), .shift_o(shift_o), .stage_vld_o(stage_vld_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Runs one tile of n iterations; inject issues a stray start mid-tile.
    task automatic run_tile(input int n, input bit inject);
        int total;
        int shifts;
        total  = (n == 0) ? 0 : (n * II + (STAGES - 1) * II);
        shifts = 0;
        @(negedge clk);
        start_i = 1'b1;
        trip_cnt_i = TRIP_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c <= total; c++) begin
            if (c > 0) @(negedge clk);
            start_i = 1'b0;
            if (c < total) begin
                int s;
                int ev;
                s = c / II;
                ev = 0;
                for (int k = 0; k < STAGES; k++)
                    if ((s - k >= 0) && (s - k < n)) ev |= (1 << k);
                chk("R2 busy", int'(busy_o), 1);
                chk("R8 done cleared", int'(done_o), 0);
                chk("R2 phase", int'(phase_o), c % II);
                chk("R3 shift", int'(shift_o), (c % II == II - 1) ? 1 : 0);
                chk("R4 stage_vld", int'(stage_vld_o), ev);
                if (shift_o) shifts++;
                if (inject && c == 2) begin
                    start_i = 1'b1;   // R7: ignored while busy
                    trip_cnt_i = 4'd9;
                end
            end else begin
                chk(n == 0 ? "R6 done" : "R5 done", int'(done_o), 1);
                chk("R5 busy", int'(busy_o), 0);
                chk("R5 stage_vld", int'(stage_vld_o), 0);
                chk("R9 phase", int'(phase_o), 0);
                chk("R9 shift", int'(shift_o), 0);
            end
        end
        chk(n == 0 ? "R6 shift count" : "R3 shift count", shifts,
            (n == 0) ? 0 : n + STAGES - 1);
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            chk("R8 done held", int'(done_o), 1);
            chk("R9 idle shift", int'(shift_o), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 shift", int'(shift_o), 0);
        chk("R1 phase", int'(phase_o), 0);
        chk("R1 stage_vld", int'(stage_vld_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(done_o), 0);
        for (int n = 1; n <= 6; n++) run_tile(n, 1'b0);
        run_tile(0, 1'b0);
        run_tile(4, 1'b1);
        run_tile(0, 1'b0);
        run_tile(2, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule